// File: doc/BRIEF.md
# Kickstart Power-On Controller

This block is the soft-power controller of a battery-backed timekeeping section. It drives an active-low system power-enable output. While main power is absent, a key press on the active-low kickstart input or a wake-up event can switch system power on. A key press counts only when the auxiliary supply is present and the battery-enable bit is set. Once main power is present, software command pulses switch the output, and the kickstart input becomes an ordinary interrupt source. It sets a flag that feeds an open-drain interrupt combiner.

The kickstart input is asynchronous. It passes through a two-flop synchronizer and a falling-edge detector, so one key press yields one event however long the key is held. The interrupt combiner merges the kickstart flag with a parameterised number of external status flags, each with its own enable. It requests the pull-down of the shared request line while any enabled flag is set.

Top module: `softpwr_ctrl`

## Requirements
- R1: After reset, pwr_no is 1 (power off), kick_flag_o is 0 and irq_oe_o is 0 (line released).
- R2: With main_pwr_i at 0, aux_ok_i at 1 and batt_en_i at 1, a high-to-low change on kick_ni drives pwr_no to 0 on the third rising clock edge after the change, and not before.
- R3: With main_pwr_i at 0, a kickstart falling edge leaves pwr_no at 1 when either batt_en_i or aux_ok_i is 0.
- R4: With main_pwr_i at 0, wake_i high at a rising edge drives pwr_no to 0 at that edge. With main_pwr_i at 1, wake_i has no effect on pwr_no.
- R5: Once power is on, pwr_no stays 0 while main_pwr_i is 0, and sw_off_i is ignored in that state.
- R6: With main_pwr_i at 1, sw_off_i high at an edge sets pwr_no to 1 and sw_on_i high sets it to 0. When both are high, the off command wins.
- R7: With main_pwr_i at 1, a kickstart falling edge sets kick_flag_o on the third edge after the change and leaves pwr_no unchanged. With main_pwr_i at 0, kick_flag_o is never set.
- R8: A kickstart input held low produces one event only. A flag cleared while the key is still held stays clear.
- R9: kick_clr_i high at an edge clears kick_flag_o. If a new kickstart event arrives at the same edge, the flag is set.
- R10: The flag vector has the kickstart flag at bit 0 and ext_flags_i[k] at bit k+1. irq_oe_o is 1 exactly when some flag bit and the matching irq_en_i bit are both 1, so the line is released only after every enabled contributing flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_pwr_i | input | 1 | Main power present |
| aux_ok_i | input | 1 | Auxiliary supply present |
| batt_en_i | input | 1 | Auxiliary battery enable bit |
| kick_ni | input | 1 | Kickstart input, active low, asynchronous |
| wake_i | input | 1 | Wake-up interrupt event |
| sw_on_i | input | 1 | Software power-on command pulse |
| sw_off_i | input | 1 | Software power-off command pulse |
| kick_clr_i | input | 1 | Clear kickstart flag |
| ext_flags_i | input | NUM_EXT | Other interrupt status flags |
| irq_en_i | input | NUM_EXT+1 | Interrupt enables, bit 0 for kickstart |
| pwr_no | output | 1 | System power enable, active low |
| kick_flag_o | output | 1 | Kickstart interrupt flag |
| irq_oe_o | output | 1 | Open-drain pull-down enable for the request line |

## Verification
A synchronizer stage reset to the wrong level, or an edge detector that does not track the previous sample, shows up as a spurious or repeated event. A spurious event powers the system on or sets the flag within three cycles of reset. A repeated event sets the flag again after software clears it during a long press. A power state register that takes commands in the wrong main-power mode is visible on pwr_no one cycle after the command. A wrong bit-to-enable pairing in the combiner is visible on irq_oe_o in the same cycle that the flag or enable changes.

// File: rtl/softpwr_pkg.sv
package softpwr_pkg;
  parameter int unsigned SP_NUM_EXT = 3;
  parameter int unsigned SP_SYNC_STAGES = 2;

  typedef enum logic {
    PWR_OFF = 1'b0,
    PWR_ON  = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/softpwr_kick_sync.sv
module softpwr_kick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_ni,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES;

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous sample
  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[LAST-1:0], kick_ni};
  end

  assign fall_o = sh_q[LAST] & ~sh_q[LAST-1];

  // R8: one press gives one event
  a_r8_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/softpwr_state.sv
module softpwr_state
  import softpwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic main_pwr_i,
  input  logic aux_ok_i,
  input  logic batt_en_i,
  input  logic kick_fall_i,
  input  logic wake_i,
  input  logic sw_on_i,
  input  logic sw_off_i,
  input  logic kick_clr_i,
  output logic pwr_on_o,
  output logic kick_flag_o
);
  pwr_state_e state_q, state_d;
  logic       flag_q, flag_d;
  logic       kick_ok;

  assign kick_ok = kick_fall_i & aux_ok_i & batt_en_i;

  always_comb begin
    state_d = state_q;
    if (main_pwr_i) begin
      if (sw_off_i)     state_d = PWR_OFF;
      else if (sw_on_i) state_d = PWR_ON;
    end else if (kick_ok || wake_i) begin
      state_d = PWR_ON;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (kick_clr_i) flag_d = 1'b0;
    if (main_pwr_i && kick_fall_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWR_OFF;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  assign pwr_on_o    = (state_q == PWR_ON);
  assign kick_flag_o = flag_q;

  a_r5_hold_on_battery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!main_pwr_i && pwr_on_o) |=> pwr_on_o);

  a_r3_gated_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!main_pwr_i && !batt_en_i && !wake_i && !pwr_on_o) |=> !pwr_on_o);

  a_r7_flag_on_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_pwr_i && kick_fall_i) |=> kick_flag_o);

  a_r7_no_flag_on_batt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!main_pwr_i && !kick_flag_o) |=> !kick_flag_o);

  a_r6_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_pwr_i && sw_off_i) |=> !pwr_on_o);
endmodule

// File: rtl/softpwr_irq.sv
module softpwr_irq #(
  parameter int unsigned NFLAG = 4
) (
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] en_i,
  output logic             irq_oe_o
);
  logic [NFLAG-1:0] hit;

  for (genvar g = 0; g < NFLAG; g++) begin : g_hit
    assign hit[g] = flags_i[g] & en_i[g];
  end

  assign irq_oe_o = |hit;
endmodule

// File: rtl/softpwr_ctrl.sv
module softpwr_ctrl
  import softpwr_pkg::*;
#(
  parameter int unsigned NUM_EXT     = SP_NUM_EXT,
  parameter int unsigned SYNC_STAGES = SP_SYNC_STAGES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               main_pwr_i,
  input  logic               aux_ok_i,
  input  logic               batt_en_i,
  input  logic               kick_ni,
  input  logic               wake_i,
  input  logic               sw_on_i,
  input  logic               sw_off_i,
  input  logic               kick_clr_i,
  input  logic [NUM_EXT-1:0] ext_flags_i,
  input  logic [NUM_EXT:0]   irq_en_i,
  output logic               pwr_no,
  output logic               kick_flag_o,
  output logic               irq_oe_o
);
  localparam int unsigned NFLAG = NUM_EXT + 1;

  logic kick_fall;
  logic pwr_on;
  logic kick_flag;

  softpwr_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_ni (kick_ni),
    .fall_o  (kick_fall)
  );

  softpwr_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .main_pwr_i  (main_pwr_i),
    .aux_ok_i    (aux_ok_i),
    .batt_en_i   (batt_en_i),
    .kick_fall_i (kick_fall),
    .wake_i      (wake_i),
    .sw_on_i     (sw_on_i),
    .sw_off_i    (sw_off_i),
    .kick_clr_i  (kick_clr_i),
    .pwr_on_o    (pwr_on),
    .kick_flag_o (kick_flag)
  );

  softpwr_irq #(.NFLAG(NFLAG)) u_irq (
    .flags_i  ({ext_flags_i, kick_flag}),
    .en_i     (irq_en_i),
    .irq_oe_o (irq_oe_o)
  );

  assign pwr_no      = ~pwr_on;
  assign kick_flag_o = kick_flag;

  a_r10_kick_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_flag && irq_en_i[0]) |-> irq_oe_o);

  a_r4_wake_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!main_pwr_i && wake_i) |=> !pwr_no);
endmodule

// File: tb/softpwr_ctrl_bench.sv
`timescale 1ns/1ps
module softpwr_ctrl_bench;
  localparam int unsigned NUM_EXT = 3;

  typedef struct {
    logic  pwr_n;
    logic  flag;
    logic  oe;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic main_pwr_i = 1'b0, aux_ok_i = 1'b0, batt_en_i = 1'b0;
  logic kick_ni = 1'b1, wake_i = 1'b0, sw_on_i = 1'b0, sw_off_i = 1'b0, kick_clr_i = 1'b0;
  logic [NUM_EXT-1:0] ext_flags_i = '0;
  logic [NUM_EXT:0]   irq_en_i = '0;
  logic pwr_no, kick_flag_o, irq_oe_o;

  exp_t q[$];
  int   applied = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  softpwr_ctrl #(.NUM_EXT(NUM_EXT)) u_softpwr_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .main_pwr_i(main_pwr_i), .aux_ok_i(aux_ok_i),
    .batt_en_i(batt_en_i), .kick_ni(kick_ni), .wake_i(wake_i), .sw_on_i(sw_on_i),
    .sw_off_i(sw_off_i), .kick_clr_i(kick_clr_i), .ext_flags_i(ext_flags_i),
    .irq_en_i(irq_en_i), .pwr_no(pwr_no), .kick_flag_o(kick_flag_o), .irq_oe_o(irq_oe_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input logic p, input logic f, input logic o, input string tag);
    exp_t e;
    e.pwr_n = p; e.flag = f; e.oe = o; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares queued expectations 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        applied++;
        if (pwr_no !== e.pwr_n || kick_flag_o !== e.flag || irq_oe_o !== e.oe) begin
          miscompares++;
          $display("FAIL %s: got pwr_no=%b flag=%b oe=%b, expected pwr_no=%b flag=%b oe=%b",
                   e.tag, pwr_no, kick_flag_o, irq_oe_o, e.pwr_n, e.flag, e.oe);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      applied++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  task automatic press_release(input int hold);
    kick_ni = 1'b0; cyc(hold);
    kick_ni = 1'b1; cyc(4);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  initial begin
    cyc(2);
    expect_now(1, 0, 0, "R1 reset");
    cyc(1);
    rst_ni = 1'b1;
    cyc(2);
    expect_now(1, 0, 0, "R1 after reset release");
    cyc(1);

    // R3: battery enable off
    aux_ok_i = 1'b1; batt_en_i = 1'b0;
    press_release(5);
    expect_now(1, 0, 0, "R3 batt_en=0");
    cyc(1);
    // R3: aux supply missing
    aux_ok_i = 1'b0; batt_en_i = 1'b1;
    press_release(5);
    expect_now(1, 0, 0, "R3 aux_ok=0");
    cyc(1);

    // R2: exact latency
    aux_ok_i = 1'b1;
    kick_ni = 1'b0;
    cyc(2);
    expect_now(1, 0, 0, "R2 not before third edge");
    cyc(1);
    expect_now(0, 0, 0, "R2 on at third edge, R7 no flag on battery");
    kick_ni = 1'b1;
    cyc(4);

    // R5: off ignored on battery
    pulse(sw_off_i);
    cyc(1);
    expect_now(0, 0, 0, "R5 off ignored without main");
    cyc(1);

    // R6
    main_pwr_i = 1'b1;
    pulse(sw_off_i);
    expect_now(1, 0, 0, "R6 off command");
    cyc(1);
    pulse(sw_on_i);
    expect_now(0, 0, 0, "R6 on command");
    cyc(1);
    sw_on_i = 1'b1; sw_off_i = 1'b1; cyc(1);
    sw_on_i = 1'b0; sw_off_i = 1'b0;
    expect_now(1, 0, 0, "R6 off wins");
    cyc(1);

    // R4
    pulse(wake_i);
    cyc(1);
    expect_now(1, 0, 0, "R4 wake ignored with main");
    cyc(1);
    main_pwr_i = 1'b0;
    pulse(wake_i);
    expect_now(0, 0, 0, "R4 wake powers on");
    cyc(1);
    main_pwr_i = 1'b1;
    pulse(sw_off_i);
    cyc(1);

    // R7: flag on main, power unchanged
    kick_ni = 1'b0;
    cyc(3);
    expect_now(1, 1, 0, "R7 flag set, power unchanged, R10 disabled");
    cyc(1);
    // R8: clear while held stays clear
    pulse(kick_clr_i);
    cyc(4);
    expect_now(1, 0, 0, "R8 held key no second event");
    cyc(1);
    kick_ni = 1'b1;
    cyc(4);
    expect_now(1, 0, 0, "R8 release no event");
    cyc(1);

    // R9: set wins over clear at the same edge
    kick_ni = 1'b0;
    cyc(2);
    pulse(kick_clr_i);
    expect_now(1, 1, 0, "R9 set wins over clear");
    cyc(1);
    kick_ni = 1'b1;
    cyc(3);

    // R10
    irq_en_i = 4'b0001;
    cyc(1);
    expect_now(1, 1, 1, "R10 kick flag enabled");
    cyc(1);
    ext_flags_i = 3'b010; irq_en_i = 4'b0101;
    pulse(kick_clr_i);
    expect_now(1, 0, 1, "R10 ext flag still holds line");
    cyc(1);
    ext_flags_i = 3'b000;
    cyc(1);
    expect_now(1, 0, 0, "R10 released after all cleared");
    cyc(1);
    ext_flags_i = 3'b100; irq_en_i = 4'b0111;
    cyc(1);
    expect_now(1, 0, 0, "R10 disabled flag ignored");
    cyc(1);
    irq_en_i = 4'b1000;
    cyc(1);
    expect_now(1, 0, 1, "R10 top ext flag enabled");
    cyc(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule